// File: doc/BRIEF.md
# Signed/Unsigned Bitfield Extract Unit

This execution unit pulls a contiguous run of bits out of a source word and returns it either zero-extended or sign-extended. The caller chooses the start position (offset) and the run length (width), and the unit delivers the field right-aligned in the result. Three operation families are supported. The 32-bit and 64-bit scalar forms take offset and width packed together in one control word, and they also return a condition flag that reports whether the result is nonzero. The vector form works on a parameterised number of 32-bit lanes. In the vector form each lane takes its own offset and its own width from two separate operand words, and an execution mask decides which lanes are written.

All results are captured in one output register stage. A strobe launches an operation, and the result, the flag and a done pulse appear on the following clock edge. Sign extension depends on the width value given at run time. When the top bit of the extracted field is set and the signed variant is selected, every bit above the field is forced to one.

Top module: `bfx_unit`

## Requirements
- R1: Opcode 0 (32-bit scalar, unsigned) returns `(s_src[31:0] >> s_ctl[4:0])` masked to its low N bits, where N is `s_ctl[22:16]`. `s_res[63:32]` is zero, and `s_src[63:32]` has no effect on the result.
- R2: Opcodes 2 and 3 (64-bit scalar, unsigned and signed) take the offset from `s_ctl[5:0]` and the width N from `s_ctl[22:16]`, and operate on all 64 bits of `s_src`.
- R3: The signed opcodes 1 (32-bit scalar), 3 (64-bit scalar) and 5 (vector) set every result bit from N up to the top of the data width when bit N-1 of the extracted field is one. The unsigned opcodes 0, 2 and 4 always leave those bits zero.
- R4: A width of zero gives a result of zero in the signed and unsigned variants alike.
- R5: A width equal to or greater than the data width (32 or 64) returns the whole shifted source, and no bits are forced by sign extension.
- R6: After a scalar operation, `s_flag` is 1 when the new `s_res` is nonzero and 0 otherwise.
- R7: Opcodes 4 and 5 (vector) compute, in each lane i, a 32-bit extract with offset `v_off` lane i bits [4:0] and width `v_wid` lane i bits [4:0]. The upper bits of those lane words are ignored.
- R8: In a vector operation, a lane whose `v_mask` bit is clear keeps its previous `v_res` value.
- R9: The results of an accepted operation appear on the clock edge after the cycle in which `op_valid` is high, and `done` is high for exactly that one cycle. While no operation is accepted, `s_res`, `s_flag` and `v_res` hold their values.
- R10: After reset, `s_res`, `s_flag`, `v_res` and `done` are all zero.
- R11: Opcodes 6 and 7 change nothing and do not raise `done`. A scalar operation leaves `v_res` unchanged, and a vector operation leaves `s_res` and `s_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Launches the operation selected by op_code |
| op_code | input | 3 | 0/1 scalar32 u/s, 2/3 scalar64 u/s, 4/5 vector u/s |
| s_src | input | 64 | Scalar source word |
| s_ctl | input | 32 | Scalar control: offset in low bits, width in [22:16] |
| v_src | input | LANES*32 | Vector source, lane i in bits [32i+31:32i] |
| v_off | input | LANES*32 | Vector offset operand per lane |
| v_wid | input | LANES*32 | Vector width operand per lane |
| v_mask | input | LANES | Execution mask, one bit per lane |
| s_res | output | 64 | Registered scalar result |
| s_flag | output | 1 | Registered nonzero flag for the scalar result |
| v_res | output | LANES*32 | Registered vector result |
| done | output | 1 | One-cycle pulse when results update |

## Verification
Both scalar forms are swept over every offset and every width from zero to beyond the data width. Each sweep is run with a source pattern and with its complement, in the signed and the unsigned variant. Because the field's top bit then takes both values at every position, the runs separate correct sign extension from zero fill and show where the width mask ends. Control bits outside the offset and width fields, and the upper source half in the 32-bit form, carry junk so that a wrongly decoded field is caught. Vector operations use random lane data, random offsets and widths with junk upper bits, and random masks, which separates written lanes from held lanes. Idle cycles, the two unused opcodes and alternating scalar and vector operations confirm the hold and isolation rules.

// File: rtl/bfx_pkg.sv
`timescale 1ns/1ps
package bfx_pkg;
   localparam int S32_W    = 32;
   localparam int S64_W    = 64;
   localparam int LANE_W   = 32;
   localparam int CTL_W    = 32;
   localparam int WID_LSB  = 16;
   localparam int WID_W    = 7;
   localparam int OFF32_W  = 5;
   localparam int OFF64_W  = 6;

   typedef enum logic [2:0] {
      OP_S32_U = 3'd0,
      OP_S32_S = 3'd1,
      OP_S64_U = 3'd2,
      OP_S64_S = 3'd3,
      OP_VEC_U = 3'd4,
      OP_VEC_S = 3'd5,
      OP_NOP6  = 3'd6,
      OP_NOP7  = 3'd7
   } bfx_op_e;

   function automatic logic op_is_scalar(bfx_op_e op);
      return (op == OP_S32_U) || (op == OP_S32_S) ||
             (op == OP_S64_U) || (op == OP_S64_S);
   endfunction

   function automatic logic op_is_vec(bfx_op_e op);
      return (op == OP_VEC_U) || (op == OP_VEC_S);
   endfunction

   function automatic logic op_is_signed(bfx_op_e op);
      return (op == OP_S32_S) || (op == OP_S64_S) || (op == OP_VEC_S);
   endfunction
endpackage

// File: rtl/bfx_core.sv
`timescale 1ns/1ps
// Combinational field extractor for one data width.
module bfx_core #(
   parameter int DATA_W = 32,
   parameter int OFF_W  = 5,
   parameter int WID_W  = 7
) (
   input  logic [DATA_W-1:0] src,
   input  logic [OFF_W-1:0]  off,
   input  logic [WID_W-1:0]  wid,
   input  logic              sgn,
   output logic [DATA_W-1:0] res
);
   localparam int CNT_W = $clog2(DATA_W + 1);

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("bfx_core: DATA_W must be at least 2");
      end
      if ((1 << OFF_W) > DATA_W) begin : g_bad_off
         $error("bfx_core: offset field wider than data word");
      end
   endgenerate

   logic [CNT_W-1:0]  len;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] keep;
   logic [DATA_W-1:0] top_bit;
   logic [DATA_W-1:0] field;
   logic              neg;

   always_comb begin
      // clamp the run length to the data width
      if (int'(wid) >= DATA_W) len = CNT_W'(DATA_W);
      else                     len = CNT_W'(wid);
      shifted = src >> off;
      // len == DATA_W shifts every one out, giving an all-ones keep mask
      keep    = ~({DATA_W{1'b1}} << len);
      top_bit = keep & ~(keep >> 1);
      field   = shifted & keep;
      neg     = sgn & (|(field & top_bit));
      res     = neg ? (field | ~keep) : field;
   end
endmodule

// File: rtl/bfx_scalar.sv
`timescale 1ns/1ps
// Scalar path: 32-bit and 64-bit extract with nonzero flag.
module bfx_scalar
   import bfx_pkg::*;
(
   input  logic [S64_W-1:0] src,
   input  logic [CTL_W-1:0] ctl,
   input  bfx_op_e          op,
   output logic [S64_W-1:0] res,
   output logic             flag
);
   logic [WID_W-1:0] wid_fld;
   logic [S32_W-1:0] res32;
   logic [S64_W-1:0] res64;
   logic             sgn;
   logic             ctl_unused;

   assign wid_fld    = ctl[WID_LSB +: WID_W];
   assign sgn        = op_is_signed(op);
   assign ctl_unused = ^{ctl[CTL_W-1:WID_LSB+WID_W], ctl[WID_LSB-1:OFF64_W]};

   bfx_core #(.DATA_W(S32_W), .OFF_W(OFF32_W), .WID_W(WID_W)) core32_i (
      .src (src[S32_W-1:0]),
      .off (ctl[OFF32_W-1:0]),
      .wid (wid_fld),
      .sgn (sgn),
      .res (res32)
   );

   bfx_core #(.DATA_W(S64_W), .OFF_W(OFF64_W), .WID_W(WID_W)) core64_i (
      .src (src),
      .off (ctl[OFF64_W-1:0]),
      .wid (wid_fld),
      .sgn (sgn),
      .res (res64)
   );

   always_comb begin
      if ((op == OP_S64_U) || (op == OP_S64_S)) res = res64;
      else                                      res = {{(S64_W-S32_W){1'b0}}, res32};
      flag = |res;
   end
endmodule

// File: rtl/bfx_lanes.sv
`timescale 1ns/1ps
// Vector path: one extractor per lane, fields taken per lane.
module bfx_lanes
   import bfx_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic [LANES*LANE_W-1:0] src,
   input  logic [LANES*LANE_W-1:0] off,
   input  logic [LANES*LANE_W-1:0] wid,
   input  logic                    sgn,
   output logic [LANES*LANE_W-1:0] res
);
   localparam int FLD_W = OFF32_W;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [LANE_W-1:0] lane_off;
         logic [LANE_W-1:0] lane_wid;
         logic              lane_unused;

         assign lane_off    = off[i*LANE_W +: LANE_W];
         assign lane_wid    = wid[i*LANE_W +: LANE_W];
         assign lane_unused = ^{lane_off[LANE_W-1:FLD_W], lane_wid[LANE_W-1:FLD_W]};

         bfx_core #(.DATA_W(LANE_W), .OFF_W(FLD_W), .WID_W(FLD_W)) core_i (
            .src (src[i*LANE_W +: LANE_W]),
            .off (lane_off[FLD_W-1:0]),
            .wid (lane_wid[FLD_W-1:0]),
            .sgn (sgn),
            .res (res[i*LANE_W +: LANE_W])
         );
      end
   endgenerate
endmodule

// File: rtl/bfx_unit.sv
`timescale 1ns/1ps
// Bitfield extract unit with one output register stage.
module bfx_unit
   import bfx_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    op_valid,
   input  logic [2:0]              op_code,
   input  logic [S64_W-1:0]        s_src,
   input  logic [CTL_W-1:0]        s_ctl,
   input  logic [LANES*LANE_W-1:0] v_src,
   input  logic [LANES*LANE_W-1:0] v_off,
   input  logic [LANES*LANE_W-1:0] v_wid,
   input  logic [LANES-1:0]        v_mask,
   output logic [S64_W-1:0]        s_res,
   output logic                    s_flag,
   output logic [LANES*LANE_W-1:0] v_res,
   output logic                    done
);
   localparam int VEC_W = LANES * LANE_W;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("bfx_unit: LANES must be at least 1");
      end
   endgenerate

   bfx_op_e           op;
   logic              take_s;
   logic              take_v;
   logic [S64_W-1:0]  s_nxt;
   logic              f_nxt;
   logic [VEC_W-1:0]  v_nxt;

   assign op     = bfx_op_e'(op_code);
   assign take_s = op_valid & op_is_scalar(op);
   assign take_v = op_valid & op_is_vec(op);

   bfx_scalar scalar_i (
      .src  (s_src),
      .ctl  (s_ctl),
      .op   (op),
      .res  (s_nxt),
      .flag (f_nxt)
   );

   bfx_lanes #(.LANES(LANES)) lanes_i (
      .src (v_src),
      .off (v_off),
      .wid (v_wid),
      .sgn (op_is_signed(op)),
      .res (v_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_res  <= '0;
         s_flag <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= take_s | take_v;
         if (take_s) begin
            s_res  <= s_nxt;
            s_flag <= f_nxt;
         end
      end
   end

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_vreg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_res[i*LANE_W +: LANE_W] <= '0;
            end else if (take_v && v_mask[i]) begin
               v_res[i*LANE_W +: LANE_W] <= v_nxt[i*LANE_W +: LANE_W];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/bfx_unit_chk.sv
`timescale 1ns/1ps
module bfx_unit_chk #(
   parameter int LANES = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 op_valid,
   input logic [2:0]           op_code,
   input logic [31:0]          s_ctl,
   input logic [LANES-1:0]     v_mask,
   input logic [63:0]          s_res,
   input logic                 s_flag,
   input logic [LANES*32-1:0]  v_res,
   input logic                 done
);
   logic acc_s;
   logic acc_v;
   assign acc_s = op_valid && (op_code <= 3'd3);
   assign acc_v = op_valid && ((op_code == 3'd4) || (op_code == 3'd5));

   // R9: done follows an accepted operation by one cycle
   a_r9_done_after_op: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_s || acc_v) |=> done);
   // R11: no accepted operation means no done
   a_r11_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_s || acc_v) |=> !done);
   // R9: idle cycles hold every result
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_s || acc_v) |=> ($stable(s_res) && $stable(s_flag) && $stable(v_res)));
   // R6: flag mirrors a nonzero scalar result
   a_r6_flag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      acc_s |=> (s_flag == (s_res != 64'd0)));
   // R1: 32-bit forms clear the upper result half
   a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code <= 3'd1)) |=> (s_res[63:32] == 32'd0));
   // R4: zero width gives zero
   a_r4_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_s && (s_ctl[22:16] == 7'd0)) |=> (s_res == 64'd0));
   // R11: scalar operations leave the vector result alone
   a_r11_scalar_keeps_vec: assert property (@(posedge clk) disable iff (!rst_n)
      acc_s |=> $stable(v_res));
   // R11: vector operations leave the scalar result alone
   a_r11_vec_keeps_scalar: assert property (@(posedge clk) disable iff (!rst_n)
      acc_v |=> ($stable(s_res) && $stable(s_flag)));

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
         // R8: masked-off lanes hold
         a_r8_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_v && !v_mask[i]) |=> $stable(v_res[i*32 +: 32]));
      end
   endgenerate
endmodule

bind bfx_unit bfx_unit_chk #(.LANES(LANES)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_code  (op_code),
   .s_ctl    (s_ctl),
   .v_mask   (v_mask),
   .s_res    (s_res),
   .s_flag   (s_flag),
   .v_res    (v_res),
   .done     (done)
);

// File: tb/bfx_unit_tb_top.sv
`timescale 1ns/1ps
module bfx_unit_tb_top;
   localparam int LANES = 4;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                op_valid = 1'b0;
   logic [2:0]          op_code = 3'd0;
   logic [63:0]         s_src = '0;
   logic [31:0]         s_ctl = '0;
   logic [LANES*32-1:0] v_src = '0;
   logic [LANES*32-1:0] v_off = '0;
   logic [LANES*32-1:0] v_wid = '0;
   logic [LANES-1:0]    v_mask = '0;
   logic [63:0]         s_res;
   logic                s_flag;
   logic [LANES*32-1:0] v_res;
   logic                done;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_v [LANES];

   always #4 clk = ~clk; // 125 MHz

   bfx_unit #(.LANES(LANES)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .s_src(s_src), .s_ctl(s_ctl), .v_src(v_src), .v_off(v_off),
      .v_wid(v_wid), .v_mask(v_mask), .s_res(s_res), .s_flag(s_flag),
      .v_res(v_res), .done(done)
   );

   // bit-by-bit reference model
   function automatic logic [63:0] ref_bfx(logic [63:0] src, int off, int wid, int dw, bit sgn);
      logic [63:0] r;
      int n;
      r = '0;
      n = (wid > dw) ? dw : wid;
      for (int i = 0; i < dw; i++)
         if (i < n && (i + off) < dw) r[i] = src[i + off];
      if (sgn && n > 0 && n < dw && r[n-1])
         for (int i = n; i < dw; i++) r[i] = 1'b1;
      return r;
   endfunction

   task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_vec(string tag);
      for (int i = 0; i < LANES; i++)
         chk(tag, {96'd0, v_res[i*32 +: 32]}, {96'd0, exp_v[i]});
   endtask

   task automatic run_scalar(logic [2:0] code, logic [63:0] src, int off, int wid);
      logic [63:0] e;
      int dw;
      bit sg;
      string tag;
      dw = (code <= 3'd1) ? 32 : 64;
      sg = code[0];
      @(negedge clk);
      op_valid = 1'b1;
      op_code  = code;
      s_src    = src;
      s_ctl    = {9'h15A, 7'(wid), 10'h2B5, 6'(off)};
      if (dw == 32) s_ctl[5] = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      e = ref_bfx(src, off, wid, dw, sg);
      if (wid == 0)       tag = "R4";
      else if (wid >= dw) tag = "R5";
      else if (sg)        tag = "R3";
      else if (dw == 32)  tag = "R1";
      else                tag = "R2";
      chk(tag, {64'd0, s_res}, {64'd0, e});
      chk("R6", {127'd0, s_flag}, {127'd0, (e != 64'd0)});
      chk("R9", {127'd0, done}, 128'd1);
   endtask

   task automatic run_vec(bit sg, logic [LANES-1:0] m);
      logic [31:0] src_l;
      logic [31:0] off_l;
      logic [31:0] wid_l;
      @(negedge clk);
      op_valid = 1'b1;
      op_code  = sg ? 3'd5 : 3'd4;
      v_mask   = m;
      for (int i = 0; i < LANES; i++) begin
         src_l = $urandom;
         off_l = $urandom;
         wid_l = $urandom;
         v_src[i*32 +: 32] = src_l;
         v_off[i*32 +: 32] = off_l;
         v_wid[i*32 +: 32] = wid_l;
         if (m[i]) exp_v[i] = 32'(ref_bfx({32'd0, src_l}, int'(off_l[4:0]), int'(wid_l[4:0]), 32, sg));
      end
      @(negedge clk);
      op_valid = 1'b0;
      for (int i = 0; i < LANES; i++)
         chk(m[i] ? "R7" : "R8", {96'd0, v_res[i*32 +: 32]}, {96'd0, exp_v[i]});
      chk("R9", {127'd0, done}, 128'd1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] held_s;
      logic        held_f;
      for (int i = 0; i < LANES; i++) exp_v[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10", {64'd0, s_res}, 128'd0);
      chk("R10", {127'd0, s_flag}, 128'd0);
      chk("R10", {127'd0, done}, 128'd0);
      check_vec("R10");

      // scalar 32-bit sweeps
      for (int p = 0; p < 2; p++)
         for (int sg = 0; sg < 2; sg++)
            for (int off = 0; off < 32; off++)
               for (int wid = 0; wid <= 40; wid++)
                  run_scalar(3'(sg), p == 0 ? 64'hDEAD_BEEF_8F0F_35A1 : 64'h2152_4110_70F0_CA5E, off, wid);

      // scalar 64-bit sweeps
      for (int p = 0; p < 2; p++)
         for (int sg = 0; sg < 2; sg++)
            for (int off = 0; off < 64; off++)
               for (int wid = 0; wid <= 70; wid++)
                  run_scalar(3'(2 + sg), p == 0 ? 64'hF00D_1234_8765_C0DE : 64'h0FF2_EDCB_789A_3F21, off, wid);

      // R11 scalar keeps vector: result still zero from reset here
      check_vec("R11");

      // vector operations with random masks
      for (int k = 0; k < 400; k++) run_vec(k[0], LANES'($urandom));
      run_vec(1'b1, '1);
      run_vec(1'b0, '0);

      // R9 idle hold and done drop
      held_s = s_res;
      held_f = s_flag;
      @(negedge clk);
      chk("R9", {127'd0, done}, 128'd0);
      chk("R9", {64'd0, s_res}, {64'd0, held_s});
      check_vec("R9");

      // R11 unused opcodes
      for (int c = 6; c < 8; c++) begin
         @(negedge clk);
         op_valid = 1'b1;
         op_code  = 3'(c);
         s_src    = '1;
         s_ctl    = 32'h0010_0000;
         v_mask   = '1;
         @(negedge clk);
         op_valid = 1'b0;
         chk("R11", {127'd0, done}, 128'd0);
         chk("R11", {64'd0, s_res}, {64'd0, held_s});
         chk("R11", {127'd0, s_flag}, {127'd0, held_f});
         check_vec("R11");
      end

      // R11 vector op leaves scalar result
      run_vec(1'b1, '1);
      chk("R11", {64'd0, s_res}, {64'd0, held_s});
      chk("R11", {127'd0, s_flag}, {127'd0, held_f});
      // and a scalar op leaves vector result
      run_scalar(3'd1, 64'h0000_0000_0000_0080, 4, 4);
      check_vec("R11");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule